// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the frequency of one clock picked from a bank of source clocks. Software writes a single control word that holds the window length in microseconds, the source index, the mode bits and a start strobe. The reference clock is divided down to a 1 us tick, and the selected clock's rising edges are counted during a window of that many ticks. When the window has closed and the count has settled, the count is copied into a 20-bit result register and the busy flag drops. An interrupt level can announce the result.

The edges are counted in the measured clock's own domain. The gate reaches that domain through a two-flop synchronizer. Around each window, the reference side keeps the gate low for a fixed settle period of `SETTLE` reference cycles, first before the window opens and again after it closes. During that time the remote counter can clear and then stop. The count is therefore static when the reference side samples it. This holds as long as the measured clock period is shorter than about a quarter of the settle period.

Either of two modes can be chosen. In one-shot mode the unit makes a single measurement for each start. In continuous mode a new window begins as soon as each result has been captured. The block has no data stream and no back-pressure: the register write port takes one word in any cycle, and readback is a plain combinational view.

Top module: `clk_freq_meter`

## Requirements
- R1: Control readback holds gate length minus one in bits 15:0, enable in bit 16, continuous mode in bit 17, interrupt enable in bit 18 and source select in bits 26:20. Bit 31 is the read-only busy flag. Bit 19 and all other bits read zero. Everything reads zero after reset.
- R2: After an accepted start, busy stays high for exactly 2*SETTLE + (len+1)*TICK_DIV reference cycles, where len is the written value of bits 15:0.
- R3: A start is accepted only when one write has bit 16 and bit 19 both set and the unit is not busy. Enable without the strobe, or a strobe while busy, starts nothing.
- R4: A write with bit 16 clear forces busy and irq low in the very next cycle. The unit is then idle.
- R5: The captured result equals the number of rising edges of source `clk_src[sel]` during the window, within 2 of window_cycles * T_ref / T_src.
- R6: The result register changes only in the cycle of a capture. In particular, it holds after a one-shot completes until the next capture.
- R7: irq rises together with the capture if bit 18 is set. It stays high until a disable or an accepted start, and it never rises with bit 18 clear.
- R8: In continuous mode busy stays high. A fresh result is captured every (len+1)*TICK_DIV + SETTLE cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src | input | NUM_SRC | Bank of clocks to be measured |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register readback including busy |
| result_rdata | output | CNT_W | Last captured edge count |
| irq | output | 1 | Completion interrupt level |

## Verification
In some cycles a software write and the sequencer's own transitions fall on the same edge. Examples are a disable written while a capture is due, a start strobe arriving while busy, and a new start issued while the previous completion still holds irq high. The bench provokes each of these by issuing writes in the middle of windows and right after completion. A behavioural countdown model is updated on every edge and gives write priority over the sequencer. Busy, irq and the readback word are compared against it in every cycle, and each capture is checked against the expected edge count.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int LEN_W     = 16;
  localparam int EN_BIT    = 16;
  localparam int CONT_BIT  = 17;
  localparam int IE_BIT    = 18;
  localparam int START_BIT = 19;
  localparam int SEL_LSB   = 20;
  localparam int SEL_W     = 7;
  localparam int BUSY_BIT  = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_GATE, ST_HOLD, ST_DONE
  } cfm_state_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             ie;
    logic             cont;
    logic             en;
    logic [LEN_W-1:0] len;
  } cfm_ctrl_t;
endpackage

// File: rtl/cfm_tick_gen.sv
module cfm_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dcnt <= '0;
    else if (!run)          dcnt <= '0;
    else if (dcnt == LAST)  dcnt <= '0;
    else                    dcnt <= dcnt + 1'b1;
  end

  assign tick = run && (dcnt == LAST);

  generate
    if (DIV > 1) begin : g_tick_chk
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/cfm_edge_counter.sv
module cfm_edge_counter #(
  parameter int CNT_W = 20
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             gate_ref,
  output logic [CNT_W-1:0] count
);
  logic g1, g2, g3;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      g1 <= 1'b0;
      g2 <= 1'b0;
      g3 <= 1'b0;
    end else begin
      g1 <= gate_ref;
      g2 <= g1;
      g3 <= g2;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n)         count <= '0;
    else if (g2 && !g3) count <= CNT_W'(1);
    else if (g2)        count <= count + 1'b1;
  end
endmodule

// File: rtl/cfm_seq.sv
module cfm_seq import cfm_pkg::*; #(
  parameter int SETTLE = 8,
  parameter int CNT_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             cont,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  input  logic [CNT_W-1:0] edge_cnt,
  output logic             tick_run,
  output logic             gate,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] result
);
  localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE - 1);

  cfm_state_e       state;
  logic [SW-1:0]    scnt;
  logic [LEN_W-1:0] ucnt;

  assign busy     = (state == ST_ARM) || (state == ST_GATE) || (state == ST_HOLD);
  assign tick_run = (state == ST_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      scnt   <= '0;
      ucnt   <= '0;
      done   <= 1'b0;
      result <= '0;
    end else if (stop_req) begin
      state <= ST_IDLE;
      scnt  <= '0;
      done  <= 1'b0;
    end else if (start_req && !busy) begin
      state <= ST_ARM;
      scnt  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_ARM: begin
          if (scnt == S_LAST) begin
            state <= ST_GATE;
            scnt  <= '0;
            ucnt  <= '0;
          end else scnt <= scnt + 1'b1;
        end
        ST_GATE: begin
          if (tick) begin
            if (ucnt == len) begin
              state <= ST_HOLD;
              scnt  <= '0;
            end else ucnt <= ucnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (scnt == S_LAST) begin
            result <= edge_cnt;
            done   <= 1'b1;
            scnt   <= '0;
            ucnt   <= '0;
            state  <= cont ? ST_GATE : ST_DONE;
          end else scnt <= scnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= (state == ST_GATE);
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !stop_req && !busy) |=> busy); // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!busy && !done)); // R4
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_req) |=> $stable(result)); // R6
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stop_req && !(start_req && !busy)) |=> done); // R7
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter import cfm_pkg::*; #(
  parameter int NUM_SRC  = 128,
  parameter int TICK_DIV = 100,
  parameter int SETTLE   = 8,
  parameter int CNT_W    = 20
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] clk_src,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        ctrl_rdata,
  output logic [CNT_W-1:0]   result_rdata,
  output logic               irq
);
  localparam int BANK = 1 << SEL_W;

  cfm_ctrl_t        ctrl_q;
  logic             start_req, stop_req;
  logic             mclk, tick, tick_run, gate, busy, done;
  logic [CNT_W-1:0] edge_cnt;
  logic [BANK-1:0]  bank;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (cfg_we) begin
      ctrl_q.len  <= cfg_wdata[LEN_W-1:0];
      ctrl_q.en   <= cfg_wdata[EN_BIT];
      ctrl_q.cont <= cfg_wdata[CONT_BIT];
      ctrl_q.ie   <= cfg_wdata[IE_BIT];
      ctrl_q.sel  <= cfg_wdata[SEL_LSB +: SEL_W];
    end
  end

  assign start_req = cfg_we && cfg_wdata[EN_BIT] && cfg_wdata[START_BIT];
  assign stop_req  = cfg_we && !cfg_wdata[EN_BIT];

  generate
    if (NUM_SRC >= BANK) begin : g_full
      assign bank = clk_src[BANK-1:0];
    end else begin : g_pad
      assign bank = {{(BANK-NUM_SRC){1'b0}}, clk_src};
    end
  endgenerate

  assign mclk = bank[ctrl_q.sel];

  cfm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .mclk(mclk), .rst_n(rst_n), .gate_ref(gate), .count(edge_cnt)
  );

  cfm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(ref_clk), .rst_n(rst_n), .run(tick_run), .tick(tick)
  );

  cfm_seq #(.SETTLE(SETTLE), .CNT_W(CNT_W)) u_seq (
    .clk(ref_clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .cont(ctrl_q.cont), .len(ctrl_q.len), .tick(tick), .edge_cnt(edge_cnt),
    .tick_run(tick_run), .gate(gate), .busy(busy), .done(done),
    .result(result_rdata)
  );

  assign irq = done && ctrl_q.ie;

  always_comb begin
    ctrl_rdata                        = '0;
    ctrl_rdata[LEN_W-1:0]             = ctrl_q.len;
    ctrl_rdata[EN_BIT]                = ctrl_q.en;
    ctrl_rdata[CONT_BIT]              = ctrl_q.cont;
    ctrl_rdata[IE_BIT]                = ctrl_q.ie;
    ctrl_rdata[SEL_LSB +: SEL_W]      = ctrl_q.sel;
    ctrl_rdata[BUSY_BIT]              = busy;
  end

  AST_IRQ_NEEDS_IE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[IE_BIT]) |=> !irq); // R7
endmodule

// File: tb/clk_freq_meter_tb.sv
`timescale 1ns/1ps
module clk_freq_meter_tb;
  localparam int DIV = 100;
  localparam int S   = 8;
  localparam logic [31:0] MASK = 32'h07F7_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [127:0] src = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] ctrl_rdata;
  logic [19:0] result_rdata;
  logic        irq;

  always #5 clk = ~clk;
  always #3.5 src[3]   = ~src[3];
  always #6.5 src[5]   = ~src[5];
  always #2   src[100] = ~src[100];

  clk_freq_meter u_dut (
    .ref_clk(clk), .rst_n(rst_n), .clk_src(src), .cfg_we(we), .cfg_wdata(wd),
    .ctrl_rdata(ctrl_rdata), .result_rdata(result_rdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit reported = 0;

  // behavioural model
  int rem = 0, win = 0, cap_win = 0;
  bit mdone = 0, cap_evt = 0;
  logic [31:0] mctrl = '0;
  logic [19:0] last_res = '0;
  real cur_per = 7.0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem = 0; mdone = 0; mctrl = '0; cap_evt = 0;
    end else begin
      cap_evt = 0;
      if (we && !wd[16]) begin
        rem = 0; mdone = 0;
      end else if (we && wd[16] && wd[19] && rem == 0) begin
        win = (int'(wd[15:0]) + 1) * DIV; rem = 2*S + win; mdone = 0;
      end else if (rem > 0) begin
        rem--;
        if (rem == 0) begin
          mdone = 1; cap_evt = 1; cap_win = win;
          if (mctrl[17]) begin
            win = (int'(mctrl[15:0]) + 1) * DIV; rem = win + S;
          end
        end
      end
      if (we) mctrl = wd & MASK;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] exp_ctrl;
      exp_ctrl = mctrl | ((rem > 0) ? 32'h8000_0000 : 32'h0);
      chk(ctrl_rdata == exp_ctrl, "R1 ctrl readback", ctrl_rdata, exp_ctrl);
      chk(ctrl_rdata[31] == (rem > 0), "R2 busy", ctrl_rdata[31], rem > 0);
      chk(irq == (mdone && mctrl[18]), "R7 irq", irq, mdone && mctrl[18]);
      if (cap_evt) begin
        real e; real d;
        e = cap_win * 10.0 / cur_per;
        d = real'(result_rdata) - e;
        chk(d <= 2.0 && d >= -2.0, mctrl[17] ? "R8 continuous result" : "R5 result",
            result_rdata, longint'(e));
        last_res = result_rdata;
      end else begin
        chk(result_rdata == last_res, "R6 result hold", result_rdata, last_res);
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  function automatic logic [31:0] cw(input int sel, input bit ie, input bit cont,
                                      input bit en, input bit st, input int len);
    return (32'(sel) << 20) | (32'(st) << 19) | (32'(ie) << 18) | (32'(cont) << 17)
         | (32'(en) << 16) | 32'(len);
  endfunction

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ctrl_rdata == 32'h0 && irq == 1'b0 && result_rdata == 20'h0, "R1 reset", ctrl_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: enable without strobe starts nothing
    wr(cw(3, 1, 0, 1, 0, 3));
    repeat (5) @(negedge clk);
    chk(ctrl_rdata[31] == 1'b0, "R3 no strobe", ctrl_rdata[31], 0);

    // R5/R7: one-shot on source 3, 4 us window
    cur_per = 7.0;
    wr(cw(3, 1, 0, 1, 1, 3));
    repeat (440) @(negedge clk);
    chk(irq == 1'b1, "R7 irq after capture", irq, 1);

    // R7: new start clears irq; R3: strobe while busy ignored
    cur_per = 13.0;
    wr(cw(5, 0, 0, 1, 1, 1));
    chk(irq == 1'b0, "R7 irq cleared by start", irq, 0);
    repeat (60) @(negedge clk);
    wr(cw(5, 0, 0, 1, 1, 1));
    repeat (200) @(negedge clk);
    chk(irq == 1'b0, "R7 no irq with ie clear", irq, 0);

    // R4: abort mid window
    cur_per = 4.0;
    wr(cw(100, 1, 0, 1, 1, 2));
    repeat (120) @(negedge clk);
    wr(cw(100, 1, 0, 0, 0, 2));
    chk(ctrl_rdata[31] == 1'b0 && irq == 1'b0, "R4 abort", ctrl_rdata[31], 0);

    // restart right after abort
    wr(cw(100, 1, 0, 1, 1, 2));
    repeat (340) @(negedge clk);

    // R8: continuous mode on source 5, three windows, then stop
    cur_per = 13.0;
    wr(cw(5, 1, 1, 1, 1, 1));
    repeat (720) @(negedge clk);
    chk(ctrl_rdata[31] == 1'b1, "R8 busy in continuous", ctrl_rdata[31], 1);
    wr(cw(5, 1, 1, 0, 0, 1));
    repeat (20) @(negedge clk);
    chk(ctrl_rdata[31] == 1'b0 && irq == 1'b0, "R4 stop continuous", ctrl_rdata[31], 0);

    // R6: result holds while idle
    repeat (50) @(negedge clk);
    finish_run();
  end
endmodule